// File: doc/BRIEF.md
# Adaptive Cut-Through Frame Forwarder

This block sits between a byte-wide receive stream and a byte-wide transmit stream on a single port. It buffers frames in a ring memory and forwards them in one of two modes. In store-and-forward mode a frame is held until its last byte has arrived and its length and frame check sequence have been checked. Good frames are then released whole, and bad frames vanish without any notice to the sender. In cut-through mode a frame starts to leave as soon as its header bytes are in. Because the check result is known only at the end, a bad frame that has already started is marked on its final output byte with an abort flag.

A mode controller counts bad frames in fixed windows of received frames. It starts in cut-through mode. When the bad-frame count in the current window reaches a programmable threshold, it moves to store-and-forward mode. It goes back to cut-through only after a full window with no bad frame. Mode changes happen only between frames. Each frame is handled in the mode that was in force at its first byte.

The receive side has no ready signal: one byte is taken on every cycle in which `in_valid` is high. The transmit side follows valid/ready rules. While `out_valid` is high and `out_ready` is low, the byte and its flags stay fixed. A byte is consumed on a cycle with both signals high. Space is checked at the first byte of each frame. If a frame of the longest legal size plus one byte might not fit, the whole frame is discarded and a drop counter advances.

Top module: `adaptive_forwarder`

## Requirements
- R1: In store-and-forward mode, no byte of a frame is presented on the output before the frame's final byte has been taken in. A good frame leaves unchanged, FCS included, with `out_last` on its final byte and `out_abort` low.
- R2: In cut-through mode, the first byte of a frame of more than HDR_LEN bytes (default 14) becomes valid on the output in the cycle after its HDR_LEN-th byte is taken in, and not earlier.
- R3: In store-and-forward mode, a frame of legal length whose check fails produces no output byte.
- R4: In store-and-forward mode, a frame shorter than MIN_LEN (default 64) or longer than MAX_LEN (default 1518) produces no output byte.
- R5: In cut-through mode, a frame of at least HDR_LEN bytes that is bad (check failure, shorter than MIN_LEN, or longer than MAX_LEN) is sent with `out_abort` high on its final output byte. A long frame is cut to its first MAX_LEN bytes followed by its final input byte.
- R6: In cut-through mode, a frame shorter than HDR_LEN bytes produces no output byte.
- R7: The check is CRC-32 with reflected polynomial 0xEDB88320, initial value all ones and final inversion, computed over every byte except the last four. The last four bytes carry the result, least significant byte first.
- R8: After reset the mode is cut-through (`sf_mode` = 0). A bad frame whose arrival brings the window's bad count to at least `err_thresh` switches to store-and-forward. A threshold of 0 acts as 1. The window restarts on every switch.
- R9: In store-and-forward mode, once WINDOW frames (default 256) have completed with no bad frame among them, the mode returns to cut-through. Every WINDOW completed frames start a new window.
- R10: `sf_mode` changes only on the cycle after a frame's final byte is taken in.
- R11: If, at a frame's first byte, the free space is less than MAX_LEN+1 bytes, the whole frame is discarded. In that case `drop_count` rises by one, the frame produces no output, and it is not counted in the error window.
- R12: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_last` and `out_abort` hold. `out_abort` is high only with `out_last`.
- R13: After reset, `out_valid` is 0, `sf_mode` is 0 and `drop_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Receive byte present this cycle |
| in_data | input | 8 | Receive byte |
| in_last | input | 1 | Receive byte is the final byte of its frame |
| out_valid | output | 1 | Transmit byte present |
| out_data | output | 8 | Transmit byte |
| out_last | output | 1 | Transmit byte ends its frame |
| out_abort | output | 1 | Frame ending on this byte is bad (cut-through only) |
| out_ready | input | 1 | Downstream accepts the transmit byte |
| err_thresh | input | TH_W | Bad-frame count that forces store-and-forward |
| sf_mode | output | 1 | 1 = store-and-forward, 0 = cut-through |
| drop_count | output | DC_W | Saturating count of frames discarded for lack of space |

## Verification
The assertions rely on DEPTH being a power of two of at least MAX_LEN+1 and on HDR_LEN ≤ MIN_LEN ≤ MAX_LEN. Under those conditions the space check at frame start keeps the writer from reaching an unread slot, so held output bytes cannot change. The stimulus uses a shrunken configuration that meets these conditions. It sends one frame at a time, sweeps every length up to four bytes past the maximum with good and corrupted checks, and waits for each frame to drain before the next one. The only exceptions are the space-exhaustion case and a drain with a toggling ready signal.

// File: rtl/afwd_pkg.sv
package afwd_pkg;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

  typedef struct packed {
    logic       last;
    logic       abort;
    logic [7:0] data;
  } slot_t;

  // one byte of reflected CRC-32, register not inverted
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/afwd_ram.sv
module afwd_ram
  import afwd_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  slot_t         wdata,
  input  logic [AW-1:0] raddr,
  output slot_t         rdata
);
  slot_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/afwd_mode_ctl.sv
module afwd_mode_ctl #(
  parameter int WINDOW = 256,
  parameter int TH_W   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_done,
  input  logic            frame_bad,
  input  logic [TH_W-1:0] thresh,
  output logic            sf_mode
);
  localparam int FW = $clog2(WINDOW + 1);

  logic [FW-1:0]   fcnt, fcnt_n;
  logic [TH_W-1:0] ecnt, ecnt_n;
  logic            win_end, to_sf, to_ct;

  always_comb begin
    ecnt_n  = (frame_bad && ecnt != '1) ? ecnt + TH_W'(1) : ecnt;
    fcnt_n  = fcnt + FW'(1);
    win_end = (fcnt_n == FW'(WINDOW));
    to_sf   = !sf_mode && frame_bad && (ecnt_n >= thresh);
    to_ct   = sf_mode && win_end && (ecnt_n == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sf_mode <= 1'b0;
      fcnt    <= '0;
      ecnt    <= '0;
    end else if (frame_done) begin
      if (to_sf || win_end) begin
        fcnt <= '0;
        ecnt <= '0;
      end else begin
        fcnt <= fcnt_n;
        ecnt <= ecnt_n;
      end
      if (to_sf)      sf_mode <= 1'b1;
      else if (to_ct) sf_mode <= 1'b0;
    end
  end
endmodule

// File: rtl/adaptive_forwarder.sv
module adaptive_forwarder
  import afwd_pkg::*;
#(
  parameter int DEPTH   = 2048,
  parameter int HDR_LEN = 14,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518,
  parameter int WINDOW  = 256,
  parameter int TH_W    = 8,
  parameter int DC_W    = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  input  logic            in_last,
  output logic            out_valid,
  output logic [7:0]      out_data,
  output logic            out_last,
  output logic            out_abort,
  input  logic            out_ready,
  input  logic [TH_W-1:0] err_thresh,
  output logic            sf_mode,
  output logic [DC_W-1:0] drop_count
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int LW = $clog2(MAX_LEN + 2);

  logic [PW-1:0] wr_ptr, rd_ptr, vis_ptr, frm_start;
  logic [PW-1:0] wr_ptr_n, start_eff, free;
  logic          in_frame, cur_sf, dropping;
  logic [31:0]   crc, crc_n;
  logic [LW-1:0] cnt, cnt_n;
  logic          first, sf_eff, drop_eff, bad, store;
  slot_t         wslot, rslot;

  always_comb begin
    first     = !in_frame;
    sf_eff    = first ? sf_mode : cur_sf;
    free      = PW'(DEPTH) - (wr_ptr - rd_ptr);
    drop_eff  = first ? (free < PW'(MAX_LEN + 1)) : dropping;
    start_eff = first ? wr_ptr : frm_start;
    if (first)                          cnt_n = LW'(1);
    else if (cnt == LW'(MAX_LEN + 1))   cnt_n = cnt;
    else                                cnt_n = cnt + LW'(1);
    crc_n = crc_step(first ? 32'hFFFF_FFFF : crc, in_data);
    bad   = (cnt_n < LW'(MIN_LEN)) || (cnt_n > LW'(MAX_LEN)) || (crc_n != CRC_RESIDUE);
    // long frames keep only their legal prefix; in cut-through the end byte is kept too
    store = in_valid && !drop_eff && ((cnt_n <= LW'(MAX_LEN)) || (in_last && !sf_eff));
    wr_ptr_n = wr_ptr + PW'(store);
    wslot = '{last: in_last, abort: in_last && bad, data: in_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      vis_ptr    <= '0;
      frm_start  <= '0;
      in_frame   <= 1'b0;
      cur_sf     <= 1'b0;
      dropping   <= 1'b0;
      crc        <= '1;
      cnt        <= '0;
      drop_count <= '0;
    end else if (in_valid) begin
      in_frame <= !in_last;
      cnt      <= cnt_n;
      crc      <= crc_n;
      if (first) begin
        cur_sf    <= sf_mode;
        dropping  <= drop_eff;
        frm_start <= wr_ptr;
        if (drop_eff && drop_count != '1) drop_count <= drop_count + DC_W'(1);
      end
      if (!drop_eff) begin
        if (in_last) begin
          if (sf_eff ? bad : (cnt_n < LW'(HDR_LEN))) begin
            wr_ptr <= start_eff;
          end else begin
            wr_ptr  <= wr_ptr_n;
            vis_ptr <= wr_ptr_n;
          end
        end else begin
          wr_ptr <= wr_ptr_n;
          if (!sf_eff && cnt_n >= LW'(HDR_LEN)) vis_ptr <= wr_ptr_n;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         rd_ptr <= '0;
    else if (out_valid && out_ready) rd_ptr <= rd_ptr + PW'(1);
  end

  afwd_ram #(.DEPTH(DEPTH)) ram_i (
    .clk   (clk),
    .we    (store),
    .waddr (wr_ptr[AW-1:0]),
    .wdata (wslot),
    .raddr (rd_ptr[AW-1:0]),
    .rdata (rslot)
  );

  afwd_mode_ctl #(.WINDOW(WINDOW), .TH_W(TH_W)) mode_i (
    .clk        (clk),
    .rst        (rst),
    .frame_done (in_valid && in_last && !drop_eff),
    .frame_bad  (bad),
    .thresh     (err_thresh),
    .sf_mode    (sf_mode)
  );

  assign out_valid = (rd_ptr != vis_ptr);
  assign out_data  = rslot.data;
  assign out_last  = rslot.last;
  assign out_abort = rslot.abort;
endmodule

// File: rtl/afwd_chk.sv
module afwd_chk #(
  parameter int DEPTH = 2048,
  parameter int PW    = 12,
  parameter int DC_W  = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_last,
  input logic            out_valid,
  input logic            out_ready,
  input logic [7:0]      out_data,
  input logic            out_last,
  input logic            out_abort,
  input logic            sf_mode,
  input logic [DC_W-1:0] drop_count,
  input logic [PW-1:0]   wr_ptr,
  input logic [PW-1:0]   rd_ptr
);
  // R12
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last) && $stable(out_abort));

  // R12
  abort_on_last_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_abort |-> out_last);

  // R10
  mode_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (sf_mode != $past(sf_mode)) |-> $past(in_valid && in_last));

  // R11
  drop_step_chk: assert property (@(posedge clk) disable iff (rst)
    (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + DC_W'(1)) && $past(in_valid));

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr - rd_ptr) <= PW'(DEPTH));
endmodule

bind adaptive_forwarder afwd_chk #(.DEPTH(DEPTH), .PW(PW), .DC_W(DC_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_last    (in_last),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_last   (out_last),
  .out_abort  (out_abort),
  .sf_mode    (sf_mode),
  .drop_count (drop_count),
  .wr_ptr     (wr_ptr),
  .rd_ptr     (rd_ptr)
);

// File: tb/adaptive_forwarder_test.sv
module adaptive_forwarder_test;
  localparam int HDR = 6, MIN = 12, MAX = 24, DEPTH = 32, WIN = 8, TH_W = 8, DC_W = 8;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic            in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [7:0]      in_data = 8'h00;
  logic [TH_W-1:0] err_thresh = 8'd200;
  logic            out_valid, out_last, out_abort, sf_mode;
  logic [7:0]      out_data;
  logic [DC_W-1:0] drop_count;

  adaptive_forwarder #(.DEPTH(DEPTH), .HDR_LEN(HDR), .MIN_LEN(MIN), .MAX_LEN(MAX),
                       .WINDOW(WIN), .TH_W(TH_W), .DC_W(DC_W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_abort(out_abort),
    .out_ready(out_ready), .err_thresh(err_thresh), .sf_mode(sf_mode), .drop_count(drop_count));

  int errors = 0, checks = 0;
  bit m_sf = 0;
  int m_fc = 0, m_ec = 0;
  logic [7:0] fr [64];
  logic [7:0] fa [64];
  logic [7:0] rx_d [256];
  bit rx_l [256], rx_a [256];
  int rx_w = 0;

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      rx_d[rx_w % 256] = out_data;
      rx_l[rx_w % 256] = out_last;
      rx_a[rx_w % 256] = out_abort;
      rx_w = rx_w + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic build(input int len, input bit corrupt, input int seed);
    logic [31:0] c;
    if (len < 4) begin
      for (int i = 0; i < len; i++) fr[i] = 8'(seed + i);
    end else begin
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < len - 4; i++) begin
        fr[i] = 8'(seed * 7 + i * 13 + 1);
        c = c ^ {24'h0, fr[i]};
        for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      c = ~c;
      for (int k = 0; k < 4; k++) fr[len - 4 + k] = c[8*k +: 8];
      if (corrupt) fr[0] = fr[0] ^ 8'h5A;
    end
  endtask

  task automatic model_end(input bit bad);
    m_fc++;
    if (bad) m_ec++;
    if (!m_sf && bad && m_ec >= err_thresh) begin
      m_sf = 1; m_fc = 0; m_ec = 0;
    end else if (m_fc == WIN) begin
      if (m_sf && m_ec == 0) m_sf = 0;
      m_fc = 0; m_ec = 0;
    end
  endtask

  task automatic send(input int len, output bit early, output bit v0, output bit v1, output bit ml);
    early = 0; v0 = 0; v1 = 1; ml = 0;
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_data = fr[i]; in_last = (i == len - 1);
      @(negedge clk);
      if (out_valid) early = 1;
      if (i == HDR - 1) v0 = out_valid;
      if (i == HDR) v1 = out_valid;
      if (i == len - 1) ml = sf_mode;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic run_frame(input int len, input bit corrupt, input int seed, input bit toggle);
    bit early, v0, v1, ml, was_sf, bad;
    int n, mism, base;
    string req;
    build(len, corrupt, seed);
    was_sf = m_sf;
    bad = (len < MIN) || (len > MAX) || corrupt;
    base = rx_w;
    send(len, early, v0, v1, ml);
    repeat (3 * len + 10) begin
      @(posedge clk); #1;
      if (toggle) out_ready = ~out_ready;
    end
    out_ready = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    if (was_sf) n = bad ? 0 : len;
    else n = (len < HDR) ? 0 : ((len > MAX) ? MAX + 1 : len);
    if (was_sf) req = !bad ? "R1 R7" : ((len >= MIN && len <= MAX) ? "R3" : "R4");
    else req = (len < HDR) ? "R6" : (bad ? "R5" : "R2 R7");
    if (toggle) req = "R12";
    mism = 0;
    for (int i = 0; i < n && i < rx_w - base; i++) begin
      int k;
      k = (base + i) % 256;
      if (rx_d[k] != ((i == n - 1) ? fr[len - 1] : fr[i])) mism++;
      if (rx_l[k] != (i == n - 1)) mism++;
      if (rx_a[k] != ((i == n - 1) && bad && !was_sf)) mism++;
    end
    chk(rx_w - base == n, req, "frame byte count", rx_w - base, n);
    chk(mism == 0, req, "content/flag mismatches", mism, 0);
    if (was_sf) chk(!early, "R1", "output before frame end", int'(early), 0);
    else if (len > HDR) chk(!v0 && v1, "R2", "valid before/after header {v0,v1}", int'({v0, v1}), 1);
    model_end(bad);
    chk(sf_mode == m_sf, "R8/R9", "mode after frame", int'(sf_mode), int'(m_sf));
    if (m_sf != was_sf) chk(ml == was_sf, "R10", "mode during final byte", int'(ml), int'(was_sf));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit early, v0, v1, ml;
    int base, mism;
    logic [7:0] d0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R13
    chk(out_valid == 1'b0, "R13", "out_valid after reset", int'(out_valid), 0);
    chk(sf_mode == 1'b0, "R13", "sf_mode after reset", int'(sf_mode), 0);
    chk(drop_count == '0, "R13", "drop_count after reset", int'(drop_count), 0);

    // cut-through sweep, threshold out of reach
    err_thresh = 8'd200;
    for (int len = 1; len <= MAX + 4; len++) run_frame(len, 0, len, 0);

    // mixed sweep with a low threshold: switches into store-and-forward (R8)
    err_thresh = 8'd3;
    for (int len = 1; len <= MAX + 4; len++) begin
      for (int c = 0; c < 2; c++) run_frame(len, c[0], len + 40, 0);
    end

    // clean traffic returns to cut-through after a clean window (R9)
    for (int j = 0; j < 2 * WIN; j++) run_frame(16, 0, j + 100, 0);
    chk(sf_mode == 1'b0, "R9", "cut-through after clean window", int'(sf_mode), 0);

    // R11: stall output, fill buffer, second frame is discarded
    err_thresh = 8'd200;
    @(posedge clk); #1 out_ready = 1'b0;
    base = rx_w;
    build(12, 0, 90);
    for (int i = 0; i < 12; i++) fa[i] = fr[i];
    send(12, early, v0, v1, ml);
    model_end(0);
    build(16, 0, 91);
    send(16, early, v0, v1, ml);
    @(negedge clk);
    chk(drop_count == 8'd1, "R11", "drop_count after overflow", int'(drop_count), 1);
    d0 = out_data;
    chk(out_valid && d0 == fa[0], "R12", "held head byte", int'(d0), int'(fa[0]));
    repeat (3) @(negedge clk);
    chk(out_valid && out_data == d0, "R12", "byte stable under back-pressure", int'(out_data), int'(d0));
    @(posedge clk); #1 out_ready = 1'b1;
    repeat (40) @(negedge clk);
    mism = 0;
    for (int i = 0; i < 12 && i < rx_w - base; i++) begin
      if (rx_d[(base + i) % 256] != fa[i]) mism++;
      if (rx_l[(base + i) % 256] != (i == 11)) mism++;
    end
    chk(rx_w - base == 12, "R11", "only the admitted frame leaves", rx_w - base, 12);
    chk(mism == 0, "R11", "admitted frame content", mism, 0);
    chk(sf_mode == m_sf, "R11", "dropped frame not counted", int'(sf_mode), int'(m_sf));
    run_frame(16, 0, 92, 0);
    chk(drop_count == 8'd1, "R11", "no drop once space returns", int'(drop_count), 1);

    // R10: threshold 1, a bad frame switches mode only at its end
    err_thresh = 8'd1;
    run_frame(16, 1, 93, 0);
    chk(sf_mode == 1'b1, "R8", "switch on first bad frame", int'(sf_mode), 1);

    // R12: drain under toggling ready
    run_frame(16, 0, 94, 1);
    run_frame(MAX, 0, 95, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule